// File: doc/BRIEF.md
# Channel Offset Calibration Sequencer

This block removes DC offset from the digital sample stream of two converter channels, I and Q. Each channel holds a signed offset value that is subtracted from every sample of that channel on its way to the serial output stage. The subtraction clamps at full scale. Samples arrive as 15-bit two's complement words with a channel tag, and leave one cycle later with the same tag.

The offset values come from one of two places. Software can write either channel's offset directly, which is user calibration. Software can also set an arm bit, which starts an automatic run. The run waits through two programmable settling delays, one after the other. It then averages a fixed number of raw samples on each channel and loads the averages into the offset registers. In internal mode the block drives an input-short control for the whole run, so only the converter's own offset is measured. In external mode the input stays connected, so system offset is included. Output samples are flagged invalid while a run is in progress. Clearing the arm bit before capture abandons the run and leaves the offsets unchanged.

Top module: `ofs_cal_seq`

## Requirements
- R1: A calibration run begins only while the arm bit is set. The arm bit is written by `ctl_we` with `ctl_arm`=1, and `cal_busy` rises on the second clock edge after that write. With the arm bit clear, `cal_busy` stays low.
- R2: With `ctl_ext`=0 (internal mode), `in_short` is high for the whole run. With `ctl_ext`=1 (external mode), `in_short` stays low. Outside a run, `in_short` is low.
- R3: After a start, the block counts two settling timers in turn, `dly1`+1 cycles and then `dly2`+1 cycles. Samples that arrive before both timers expire take no part in the measurement.
- R4: `out_invalid` is 1 on every output sample whose input was taken while a run was in progress, and 0 otherwise.
- R5: Each output sample appears exactly one cycle after its input sample. It carries the same channel tag (`smp_is_q`: 0 = I, 1 = Q). Its value is the input minus that channel's offset.
- R6: The corrected value saturates at -16384 and +16383.
- R7: After the timers, the run takes the first 4 raw samples of each channel, and further samples are ignored. It loads each offset with the floor of that channel's average. It then sets `cal_done` and clears the arm bit.
- R8: A write with `ofs_we` loads `ofs_wdata` into the I offset when `ofs_sel`=0, or the Q offset when `ofs_sel`=1. The new value is visible on the next cycle.
- R9: Clearing the arm bit during a run returns the block to idle within two cycles. Neither offset changes, and `cal_done` stays low.
- R10: `cal_done` is cleared by any control write that sets the arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_arm | input | 1 | Arm bit value for the control write |
| ctl_ext | input | 1 | Mode for the control write: 1 = external, 0 = internal |
| dly1 | input | 16 | First settling timer reload |
| dly2 | input | 16 | Second settling timer reload |
| ofs_we | input | 1 | Direct offset write strobe |
| ofs_sel | input | 1 | Offset write target: 0 = I, 1 = Q |
| ofs_wdata | input | 15 | Offset write value (two's complement) |
| smp_valid | input | 1 | Input sample strobe |
| smp_is_q | input | 1 | Input channel tag: 0 = I, 1 = Q |
| smp_data | input | 15 | Input sample (two's complement) |
| out_valid | output | 1 | Corrected sample strobe |
| out_is_q | output | 1 | Output channel tag |
| out_data | output | 15 | Corrected, saturated sample |
| out_invalid | output | 1 | Sample taken during a calibration run |
| in_short | output | 1 | Input-short control for the analog front end |
| cal_busy | output | 1 | Calibration run in progress |
| cal_arm | output | 1 | Current arm bit |
| cal_ext | output | 1 | Current mode bit |
| cal_done | output | 1 | Last run completed its capture |
| ofs_i | output | 15 | I-channel offset register |
| ofs_q | output | 15 | Q-channel offset register |

## Verification
The assertions check the following on every cycle:
- a run never starts without the arm bit;
- the input short is driven only in internal mode and only during a run;
- output strobe and tag timing are kept;
- samples taken during a run are flagged invalid;
- capture clears the arm bit;
- the offsets change only through a host write or a completed capture.

Some behaviour can only be shown by the bench scenarios:
- the settle timers really exclude early samples;
- the first four samples are averaged with floor rounding;
- the arithmetic of the subtraction and its clamp values;
- an abort in either the settle phase or the measure phase leaves the offsets unchanged.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;

    localparam int NCH   = 2;
    localparam int CH_I  = 0;
    localparam int CH_Q  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET1,
        ST_SET2,
        ST_MEAS,
        ST_CAPT
    } cal_state_e;

    typedef struct packed {
        logic valid;
        logic is_q;
        logic inv;
    } smp_tag_t;

endpackage

// File: rtl/ofs_cal_fsm.sv
module ofs_cal_fsm
    import ofs_cal_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  logic          ctl_arm,
    input  logic          ctl_ext,
    input  logic [TW-1:0] dly1,
    input  logic [TW-1:0] dly2,
    input  logic          meas_full,
    output logic          arm_q,
    output logic          ext_q,
    output logic          done_q,
    output logic          busy,
    output logic          short_o,
    output logic          meas_clr,
    output logic          meas_en,
    output logic          cap_en
);

    cal_state_e    state;
    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            tmr    <= '0;
            arm_q  <= 1'b0;
            ext_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (ctl_we) begin
                arm_q <= ctl_arm;
                ext_q <= ctl_ext;
                if (ctl_arm) done_q <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (arm_q) begin
                        state <= ST_SET1;
                        tmr   <= dly1;
                    end
                end
                ST_SET1: begin
                    if (!arm_q) begin
                        state <= ST_IDLE;
                    end else if (tmr == '0) begin
                        state <= ST_SET2;
                        tmr   <= dly2;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_SET2: begin
                    if (!arm_q)           state <= ST_IDLE;
                    else if (tmr == '0)   state <= ST_MEAS;
                    else                  tmr   <= tmr - 1'b1;
                end
                ST_MEAS: begin
                    if (!arm_q)           state <= ST_IDLE;
                    else if (meas_full)   state <= ST_CAPT;
                end
                ST_CAPT: begin
                    arm_q  <= 1'b0;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        short_o  = busy && !ext_q;
        meas_clr = (state == ST_IDLE) && arm_q;
        meas_en  = (state == ST_MEAS);
        cap_en   = (state == ST_CAPT);
    end

endmodule

// File: rtl/ofs_cal_avg.sv
module ofs_cal_avg
    import ofs_cal_pkg::*;
#(
    parameter int SW      = 15,
    parameter int AVG_LOG = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    smp_valid,
    input  logic                    smp_is_q,
    input  logic [SW-1:0]           smp_data,
    output logic [NCH-1:0][SW-1:0]  avg,
    output logic                    full
);

    localparam int AW   = SW + AVG_LOG;
    localparam int CW   = AVG_LOG + 1;
    localparam logic [CW-1:0] NSMP = CW'(1 << AVG_LOG);

    logic [NCH-1:0] ch_full;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [AW-1:0] acc;
        logic [CW-1:0] cnt;
        logic          take;

        assign take       = en && smp_valid && (smp_is_q == (c == CH_Q)) && (cnt != NSMP);
        assign ch_full[c] = (cnt == NSMP);
        assign avg[c]     = acc[AW-1:AVG_LOG];

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                acc <= '0;
                cnt <= '0;
            end else if (take) begin
                acc <= acc + {{AVG_LOG{smp_data[SW-1]}}, smp_data};
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign full = &ch_full;

endmodule

// File: rtl/ofs_cal_corr.sv
module ofs_cal_corr
    import ofs_cal_pkg::*;
#(
    parameter int SW = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ofs_we,
    input  logic                    ofs_sel,
    input  logic [SW-1:0]           ofs_wdata,
    input  logic                    cap_en,
    input  logic [NCH-1:0][SW-1:0]  cap_val,
    input  logic                    smp_valid,
    input  logic                    smp_is_q,
    input  logic [SW-1:0]           smp_data,
    input  logic                    busy,
    output logic                    out_valid,
    output logic                    out_is_q,
    output logic [SW-1:0]           out_data,
    output logic                    out_invalid,
    output logic [NCH-1:0][SW-1:0]  ofs_o
);

    localparam int DW = SW + 1;
    localparam logic signed [DW-1:0] MAXV = {2'b00, {(SW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {2'b11, {(SW-1){1'b0}}};

    for (genvar c = 0; c < NCH; c++) begin : g_ofs
        always_ff @(posedge clk) begin
            if (rst)
                ofs_o[c] <= '0;
            else if (cap_en)
                ofs_o[c] <= cap_val[c];
            else if (ofs_we && (ofs_sel == (c == CH_Q)))
                ofs_o[c] <= ofs_wdata;
        end
    end

    logic [SW-1:0]        ofs_cur;
    logic signed [DW-1:0] diff;
    logic [SW-1:0]        clamped;
    smp_tag_t             tag_q;

    always_comb begin
        ofs_cur = smp_is_q ? ofs_o[CH_Q] : ofs_o[CH_I];
        diff    = $signed({smp_data[SW-1], smp_data}) - $signed({ofs_cur[SW-1], ofs_cur});
        if (diff > MAXV)
            clamped = MAXV[SW-1:0];
        else if (diff < MINV)
            clamped = MINV[SW-1:0];
        else
            clamped = diff[SW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q    <= '0;
            out_data <= '0;
        end else begin
            tag_q.valid <= smp_valid;
            tag_q.is_q  <= smp_is_q;
            tag_q.inv   <= busy;
            if (smp_valid) out_data <= clamped;
        end
    end

    assign out_valid   = tag_q.valid;
    assign out_is_q    = tag_q.is_q;
    assign out_invalid = tag_q.valid && tag_q.inv;

endmodule

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq
    import ofs_cal_pkg::*;
#(
    parameter int SW      = 15,
    parameter int TW      = 16,
    parameter int AVG_LOG = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  logic          ctl_arm,
    input  logic          ctl_ext,
    input  logic [TW-1:0] dly1,
    input  logic [TW-1:0] dly2,
    input  logic          ofs_we,
    input  logic          ofs_sel,
    input  logic [SW-1:0] ofs_wdata,
    input  logic          smp_valid,
    input  logic          smp_is_q,
    input  logic [SW-1:0] smp_data,
    output logic          out_valid,
    output logic          out_is_q,
    output logic [SW-1:0] out_data,
    output logic          out_invalid,
    output logic          in_short,
    output logic          cal_busy,
    output logic          cal_arm,
    output logic          cal_ext,
    output logic          cal_done,
    output logic [SW-1:0] ofs_i,
    output logic [SW-1:0] ofs_q
);

    logic                   meas_full, meas_clr, meas_en, cap_en;
    logic [NCH-1:0][SW-1:0] avg;
    logic [NCH-1:0][SW-1:0] ofs_all;

    ofs_cal_fsm #(.TW(TW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_arm   (ctl_arm),
        .ctl_ext   (ctl_ext),
        .dly1      (dly1),
        .dly2      (dly2),
        .meas_full (meas_full),
        .arm_q     (cal_arm),
        .ext_q     (cal_ext),
        .done_q    (cal_done),
        .busy      (cal_busy),
        .short_o   (in_short),
        .meas_clr  (meas_clr),
        .meas_en   (meas_en),
        .cap_en    (cap_en)
    );

    ofs_cal_avg #(.SW(SW), .AVG_LOG(AVG_LOG)) u_avg (
        .clk       (clk),
        .rst       (rst),
        .clr       (meas_clr),
        .en        (meas_en),
        .smp_valid (smp_valid),
        .smp_is_q  (smp_is_q),
        .smp_data  (smp_data),
        .avg       (avg),
        .full      (meas_full)
    );

    ofs_cal_corr #(.SW(SW)) u_corr (
        .clk         (clk),
        .rst         (rst),
        .ofs_we      (ofs_we),
        .ofs_sel     (ofs_sel),
        .ofs_wdata   (ofs_wdata),
        .cap_en      (cap_en),
        .cap_val     (avg),
        .smp_valid   (smp_valid),
        .smp_is_q    (smp_is_q),
        .smp_data    (smp_data),
        .busy        (cal_busy),
        .out_valid   (out_valid),
        .out_is_q    (out_is_q),
        .out_data    (out_data),
        .out_invalid (out_invalid),
        .ofs_o       (ofs_all)
    );

    assign ofs_i = ofs_all[CH_I];
    assign ofs_q = ofs_all[CH_Q];

endmodule

// File: rtl/ofs_cal_chk.sv
module ofs_cal_chk #(
    parameter int SW = 15
) (
    input logic          clk,
    input logic          rst,
    input logic          ofs_we,
    input logic          smp_valid,
    input logic          smp_is_q,
    input logic          out_valid,
    input logic          out_is_q,
    input logic          out_invalid,
    input logic          in_short,
    input logic          cal_busy,
    input logic          cal_arm,
    input logic          cal_ext,
    input logic          cal_done,
    input logic [SW-1:0] ofs_i,
    input logic [SW-1:0] ofs_q
);

    p_start_armed_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_busy) |-> $past(cal_arm));

    p_short_mode_r2: assert property (@(posedge clk) disable iff (rst)
        in_short |-> (cal_busy && !cal_ext));

    p_short_int_r2: assert property (@(posedge clk) disable iff (rst)
        (cal_busy && !cal_ext) |-> in_short);

    p_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(smp_valid));

    p_tag_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_is_q == $past(smp_is_q)));

    p_flag_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cal_busy)) |-> out_invalid);

    p_flag_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(cal_busy) |-> !out_invalid);

    p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_done) |-> (!cal_arm && !cal_busy));

    p_ofs_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(ofs_we) && !$rose(cal_done)) |-> ($stable(ofs_i) && $stable(ofs_q)));

endmodule

bind ofs_cal_seq ofs_cal_chk #(.SW(SW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ofs_we      (ofs_we),
    .smp_valid   (smp_valid),
    .smp_is_q    (smp_is_q),
    .out_valid   (out_valid),
    .out_is_q    (out_is_q),
    .out_invalid (out_invalid),
    .in_short    (in_short),
    .cal_busy    (cal_busy),
    .cal_arm     (cal_arm),
    .cal_ext     (cal_ext),
    .cal_done    (cal_done),
    .ofs_i       (ofs_i),
    .ofs_q       (ofs_q)
);

// File: tb/test_ofs_cal_seq.sv
module test_ofs_cal_seq;

    localparam int SW = 15;
    localparam int TW = 16;
    localparam int D1 = 20;
    localparam int D2 = 30;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_we = 1'b0, ctl_arm = 1'b0, ctl_ext = 1'b0;
    logic [TW-1:0] dly1 = TW'(D1), dly2 = TW'(D2);
    logic          ofs_we = 1'b0, ofs_sel = 1'b0;
    logic [SW-1:0] ofs_wdata = '0;
    logic          smp_valid = 1'b0, smp_is_q = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          out_valid, out_is_q, out_invalid, in_short;
    logic          cal_busy, cal_arm, cal_ext, cal_done;
    logic [SW-1:0] out_data, ofs_i, ofs_q;

    always #2 clk = ~clk;

    ofs_cal_seq i_ofs_cal_seq (.*);

    typedef struct {
        logic        q;
        int          val;
        logic        inv;
        string       req;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   ofs_m[2] = '{0, 0};
    bit   finished = 0;

    function automatic int sat(int v);
        if (v > 16383)  return 16383;
        if (v < -16384) return -16384;
        return v;
    endfunction

    function automatic int sx(logic [SW-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl_write(logic arm, logic ext);
        ctl_we = 1'b1; ctl_arm = arm; ctl_ext = ext;
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic ofs_write(logic sel, int v);
        ofs_we = 1'b1; ofs_sel = sel; ofs_wdata = SW'(v);
        tick();
        ofs_we = 1'b0;
        ofs_m[sel] = v;
    endtask

    // driver: pushes the expected corrected sample, then drives the input
    task automatic send(logic q, int v, logic inv, string req);
        exp_t e;
        e.q = q; e.val = sat(v - ofs_m[q]); e.inv = inv; e.req = req;
        sbq.push_back(e);
        smp_valid = 1'b1; smp_is_q = q; smp_data = SW'(v);
        tick();
        smp_valid = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sbq.size() == 0) begin
                check("R5 unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check({e.req, " data"}, sx(out_data), e.val);
                check({e.req, " tag"}, int'(out_is_q), int'(e.q));
                check("R4 invalid flag", int'(out_invalid), int'(e.inv));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick();

        // reset state
        check("reset cal_busy", int'(cal_busy), 0);
        check("reset cal_done", int'(cal_done), 0);
        check("reset cal_arm", int'(cal_arm), 0);
        check("reset ofs_i", sx(ofs_i), 0);
        check("reset ofs_q", sx(ofs_q), 0);
        check("reset in_short", int'(in_short), 0);

        // R5: plain pass-through with zero offsets
        send(1'b0, 100, 1'b0, "R5");
        send(1'b1, -200, 1'b0, "R5");
        tick(2);

        // R8: direct offset writes
        ofs_write(1'b0, 50);
        check("R8 ofs_i after write", sx(ofs_i), 50);
        ofs_write(1'b1, -30);
        check("R8 ofs_q after write", sx(ofs_q), -30);
        check("R8 ofs_i untouched", sx(ofs_i), 50);
        send(1'b0, 1000, 1'b0, "R5");
        send(1'b1, 1000, 1'b0, "R5");

        // R6: saturation at both limits
        send(1'b0, -16380, 1'b0, "R6 low clamp");
        send(1'b1, 16370, 1'b0, "R6 high clamp");
        send(1'b0, 16383, 1'b0, "R6 no clamp");
        tick(2);

        // R1: without arm nothing starts
        ctl_write(1'b0, 1'b0);
        tick(5);
        check("R1 idle without arm", int'(cal_busy), 0);

        // internal-mode calibration
        ctl_write(1'b1, 1'b0);
        tick(2);
        check("R1 busy after arm", int'(cal_busy), 1);
        check("R2 short in internal mode", int'(in_short), 1);
        for (int k = 0; k < 19; k++) begin
            send(1'b0, 3000, 1'b1, "R3 settle sample");
            send(1'b1, -3000, 1'b1, "R3 settle sample");
        end
        tick(50 - 40);
        check("R3 still settling", int'(cal_busy), 1);
        check("R2 short held", int'(in_short), 1);
        tick(10);
        send(1'b0, 10, 1'b1, "R7 meas");
        send(1'b1, -5, 1'b1, "R7 meas");
        send(1'b0, 11, 1'b1, "R7 meas");
        send(1'b1, -6, 1'b1, "R7 meas");
        send(1'b0, 12, 1'b1, "R7 meas");
        send(1'b0, 14, 1'b1, "R7 meas");
        send(1'b0, 999, 1'b1, "R7 extra ignored");
        send(1'b1, -6, 1'b1, "R7 meas");
        send(1'b1, -6, 1'b1, "R7 meas");
        tick(3);
        check("R7 ofs_i average", sx(ofs_i), 11);
        check("R7 ofs_q average floor", sx(ofs_q), -6);
        check("R7 done set", int'(cal_done), 1);
        check("R7 arm cleared", int'(cal_arm), 0);
        check("R2 short released", int'(in_short), 0);
        ofs_m[0] = 11; ofs_m[1] = -6;
        send(1'b0, 11, 1'b0, "R5 after cal");
        send(1'b1, 0, 1'b0, "R5 after cal");
        tick(2);

        // R9 abort during settle, external mode
        ctl_write(1'b1, 1'b1);
        tick(5);
        check("R10 done cleared by arm", int'(cal_done), 0);
        check("R2 no short in external mode", int'(in_short), 0);
        check("R9 busy before abort", int'(cal_busy), 1);
        ctl_write(1'b0, 1'b1);
        tick(3);
        check("R9 idle after abort", int'(cal_busy), 0);
        check("R9 done stays low", int'(cal_done), 0);
        check("R9 ofs_i kept", sx(ofs_i), 11);
        check("R9 ofs_q kept", sx(ofs_q), -6);

        // external-mode full calibration
        ctl_write(1'b1, 1'b1);
        tick(60);
        check("R2 external no short", int'(in_short), 0);
        for (int k = 0; k < 4; k++) begin
            send(1'b0, 100, 1'b1, "R7 ext meas");
            send(1'b1, -1, 1'b1, "R7 ext meas");
        end
        tick(3);
        check("R7 ext ofs_i", sx(ofs_i), 100);
        check("R7 ext ofs_q", sx(ofs_q), -1);
        check("R7 ext done", int'(cal_done), 1);
        ofs_m[0] = 100; ofs_m[1] = -1;
        send(1'b0, 0, 1'b0, "R5 ext after");
        send(1'b1, 16383, 1'b0, "R6 clamp after cal");
        tick(2);

        // R9 abort during measurement
        ctl_write(1'b1, 1'b0);
        tick(60);
        send(1'b0, 5, 1'b1, "R9 partial meas");
        send(1'b0, 5, 1'b1, "R9 partial meas");
        ctl_write(1'b0, 1'b0);
        tick(3);
        check("R9 idle after meas abort", int'(cal_busy), 0);
        check("R9 ofs_i kept in meas", sx(ofs_i), 100);
        check("R9 ofs_q kept in meas", sx(ofs_q), -1);
        check("R10 done cleared", int'(cal_done), 0);
        send(1'b0, 200, 1'b0, "R5 final");
        tick(3);

        check("R5 scoreboard drained", sbq.size(), 0);
        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule